// File: doc/BRIEF.md
# Mixed-Width Synchronous FIFO with Threshold Flags

This block is a single-clock first-in first-out buffer built over a store of 512 slots of 9 bits. The write side and the read side each pick their own word width from 1, 2, 4, 9 or 18 bits through a 3-bit code, so a producer can push wide words while a consumer drains them narrow, or the other way round. Both sides keep a position counter in a 4096-unit address space, plus one extra wrap bit. Each accepted operation moves its counter by a step that depends on the width of that side.

The difference between the write and read counters drives four registered flags. The empty and full flags mark the two ends of the space. Almost-full and almost-empty are compared against 12-bit thresholds, whose low bits are forced to zero to match the width of the port concerned. Two configuration inputs choose whether a side refuses an operation that would overrun, or lets its counter wrap. The read port can add one optional output register. An asynchronous active-low reset returns the counters and flags to their idle state and leaves the stored data untouched.

Top module: `cfgw_fifo`

## Requirements
- R1: Width codes are 0=1 bit, 1=2 bits, 2=4 bits, 3=9 bits and 4=18 bits, and the counter steps are 1, 2, 4, 8 and 16 units. Codes 5, 6 and 7 are illegal, and an operation requested with an illegal code is ignored.
- R2: A write is requested on a rising edge when `wr_en_n` is 0 and `wr_hold` is 0. A read is requested when `rd_en` is 1 and `rd_hold` is 0. A request that is blocked by a hold input changes neither the counters nor `rd_data`.
- R3: Address bits 11:3 select a 9-bit slot. For widths 1, 2 and 4, bits 2:0, 2:1 or bit 2 select the bit, pair or nibble within slot bits 7:0, and bit 8 is skipped. Width 9 uses a whole slot. Width 18 uses slot pair {a[11:4],0} for bits 8:0 and {a[11:4],1} for bits 17:9. Narrow results are right-aligned in `rd_data`, with the upper bits 0.
- R4: With diff = write counter minus read counter, taken modulo 8192, `empty` is 1 when diff is 0 and `full` is 1 when diff is 4096. Both flags update at the same edge as the operation.
- R5: `afull` is 1 when diff >= `af_lvl`, with the low bits of `af_lvl` cleared to match the write width (none, 0, 1:0, 2:0 or 3:0). `aempty` is 1 when diff <= `ae_lvl`, with its low bits cleared to match the read width in the same way.
- R6: When `stop_full` is 1, a write is ignored if the free space (4096 - diff) is smaller than the write step. In particular, a write while `full` leaves the stored data and the flags unchanged.
- R7: When `stop_empty` is 1, a read is ignored if diff is smaller than the read step. In particular, a read while `empty` leaves `rd_data` and the flags unchanged.
- R8: When a stop input is 0, its counter advances without a guard and wraps modulo 8192. For example, a read from an empty FIFO makes diff 8192 - step, so `empty` goes to 0.
- R9: When `rd_pipe` is 0, read data appears on `rd_data` after the edge that performs the read. When `rd_pipe` is 1, it appears one edge later.
- R10: While `rst_n` is 0, the block forces `rd_data` to 0, `full` and `afull` to 0, and `empty` and `aempty` to 1, and resets both counters. This takes priority over the hold inputs. Stored data survives reset.
- R11: `rd_data` holds its value across cycles in which no read is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_width | input | 3 | Write width code |
| rd_width | input | 3 | Read width code |
| wr_data | input | 18 | Write data, right-aligned |
| wr_en_n | input | 1 | Write request, active low |
| wr_hold | input | 1 | Blocks writes when 1 |
| rd_en | input | 1 | Read request, active high |
| rd_hold | input | 1 | Blocks reads when 1 |
| af_lvl | input | 12 | Almost-full threshold, left-justified |
| ae_lvl | input | 12 | Almost-empty threshold, left-justified |
| stop_full | input | 1 | Refuse writes that would overrun |
| stop_empty | input | 1 | Refuse reads that would underrun |
| rd_pipe | input | 1 | Adds one output register on the read side |
| rd_data | output | 18 | Read data |
| full | output | 1 | FIFO full |
| empty | output | 1 | FIFO empty |
| afull | output | 1 | At or above the almost-full threshold |
| aempty | output | 1 | At or below the almost-empty threshold |

## Verification
A counter that steps by the wrong amount shows up at the flags on the edge right after the operation, because every flag is a registered function of the counter difference. A mixed-width sequence that should drain to exactly zero then fails to raise `empty`. A slot or sub-slot selection error surfaces as a wrong value on `rd_data` one edge after the read, or two edges later with the pipeline on. The wide-write/narrow-read, nibble/pair and 18/9 patterns give every position field its own distinct value. A faulty stop guard shows on the next edge: the flags change where they should hold, or data written while full appears when the FIFO is drained.

// File: rtl/cfgw_fifo_pkg.sv
`timescale 1ns/1ps
package cfgw_fifo_pkg;
  localparam int SPACE_W = 12;
  localparam int SLOT_W  = 9;
  localparam int PORT_W  = 2 * SLOT_W;
  localparam int PTR_W   = SPACE_W + 1;
  localparam int SLOT_AW = SPACE_W - 3;
  localparam int SLOTS   = 1 << SLOT_AW;
  localparam logic [PTR_W-1:0] CAP = PTR_W'(1) << SPACE_W;

  typedef enum logic [2:0] {WID_1, WID_2, WID_4, WID_9, WID_18} wid_e;

  function automatic logic code_ok(logic [2:0] c);
    return c <= 3'(WID_18);
  endfunction

  function automatic logic [PTR_W-1:0] step_of(logic [2:0] c);
    case (c)
      3'(WID_1):  return PTR_W'(1);
      3'(WID_2):  return PTR_W'(2);
      3'(WID_4):  return PTR_W'(4);
      3'(WID_9):  return PTR_W'(8);
      3'(WID_18): return PTR_W'(16);
      default:    return '0;
    endcase
  endfunction

  // clears the threshold bits below one word of the given width
  function automatic logic [SPACE_W-1:0] lvl_mask(logic [2:0] c);
    logic [PTR_W-1:0] s;
    s = step_of(c) - PTR_W'(1);
    return ~s[SPACE_W-1:0];
  endfunction

  // merge a narrow or 9-bit write into one slot
  function automatic logic [SLOT_W-1:0] slot_merge(logic [SLOT_W-1:0] old, logic [2:0] c,
                                                   logic [2:0] sel, logic [PORT_W-1:0] d);
    logic [SLOT_W-1:0] r;
    r = old;
    case (c)
      3'(WID_1): r[sel] = d[0];
      3'(WID_2): r[{sel[2:1], 1'b0} +: 2] = d[1:0];
      3'(WID_4): r[{sel[2], 2'b00} +: 4] = d[3:0];
      default:   r = d[SLOT_W-1:0];
    endcase
    return r;
  endfunction

  // pull a word of the given width out of a slot pair
  function automatic logic [PORT_W-1:0] slot_pick(logic [SLOT_W-1:0] lo, logic [SLOT_W-1:0] hi,
                                                  logic [2:0] c, logic [2:0] sel);
    logic [PORT_W-1:0] r;
    r = '0;
    case (c)
      3'(WID_1):  r[0] = lo[sel];
      3'(WID_2):  r[1:0] = lo[{sel[2:1], 1'b0} +: 2];
      3'(WID_4):  r[3:0] = lo[{sel[2], 2'b00} +: 4];
      3'(WID_18): r = {hi, lo};
      default:    r[SLOT_W-1:0] = lo;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/cfgw_ptr.sv
`timescale 1ns/1ps
module cfgw_ptr
  import cfgw_fifo_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [PTR_W-1:0] step,
  output logic [PTR_W-1:0] ptr,
  output logic [PTR_W-1:0] ptr_nxt
);
  assign ptr_nxt = go ? ptr + step : ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr <= '0;
    else        ptr <= ptr_nxt;
  end

  // R2: a side with no accepted operation keeps its position
  p_ptr_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !go |=> $stable(ptr));
endmodule

// File: rtl/cfgw_store.sv
`timescale 1ns/1ps
module cfgw_store
  import cfgw_fifo_pkg::*;
(
  input  logic               clk,
  input  logic               we,
  input  logic [2:0]         wcode,
  input  logic [SPACE_W-1:0] waddr,
  input  logic [PORT_W-1:0]  wdata,
  input  logic [2:0]         rcode,
  input  logic [SPACE_W-1:0] raddr,
  output logic [PORT_W-1:0]  rword
);
  logic [SLOT_W-1:0] slots [SLOTS];

  logic [SLOT_AW-1:0] w_lo, w_hi, w_one, r_lo, r_hi, r_one;
  logic               w_wide, r_wide;

  assign w_wide = (wcode == 3'(WID_18));
  assign r_wide = (rcode == 3'(WID_18));
  assign w_one  = waddr[SPACE_W-1:3];
  assign w_lo   = {waddr[SPACE_W-1:4], 1'b0};
  assign w_hi   = {waddr[SPACE_W-1:4], 1'b1};
  assign r_one  = raddr[SPACE_W-1:3];
  assign r_lo   = r_wide ? {raddr[SPACE_W-1:4], 1'b0} : r_one;
  assign r_hi   = {raddr[SPACE_W-1:4], 1'b1};

  // memory has no reset: contents survive rst_n
  always_ff @(posedge clk) begin
    if (we) begin
      if (w_wide) begin
        slots[w_lo] <= wdata[SLOT_W-1:0];
        slots[w_hi] <= wdata[PORT_W-1:SLOT_W];
      end else begin
        slots[w_one] <= slot_merge(slots[w_one], wcode, waddr[2:0], wdata);
      end
    end
  end

  assign rword = slot_pick(slots[r_lo], slots[r_hi], rcode, raddr[2:0]);
endmodule

// File: rtl/cfgw_flags.sv
`timescale 1ns/1ps
module cfgw_flags
  import cfgw_fifo_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PTR_W-1:0]   wptr_nxt,
  input  logic [PTR_W-1:0]   rptr_nxt,
  input  logic [SPACE_W-1:0] af_lvl,
  input  logic [SPACE_W-1:0] ae_lvl,
  input  logic [2:0]         wcode,
  input  logic [2:0]         rcode,
  output logic               full,
  output logic               empty,
  output logic               afull,
  output logic               aempty
);
  logic [PTR_W-1:0] diff_nxt, af_thr, ae_thr;

  assign diff_nxt = wptr_nxt - rptr_nxt;
  assign af_thr   = {1'b0, af_lvl & lvl_mask(wcode)};
  assign ae_thr   = {1'b0, ae_lvl & lvl_mask(rcode)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full   <= 1'b0;
      afull  <= 1'b0;
      empty  <= 1'b1;
      aempty <= 1'b1;
    end else begin
      full   <= (diff_nxt == CAP);
      empty  <= (diff_nxt == '0);
      afull  <= (diff_nxt >= af_thr);
      aempty <= (diff_nxt <= ae_thr);
    end
  end

  // R4: the two ends of the space are never flagged together
  p_ends_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));
  // R5: thresholds stay below the capacity, so full implies almost-full
  p_full_af_r5: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> afull);
  // R5: empty implies almost-empty for any threshold
  p_empty_ae_r5: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> aempty);
endmodule

// File: rtl/cfgw_rdport.sv
`timescale 1ns/1ps
module cfgw_rdport
  import cfgw_fifo_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              pipe,
  input  logic [PORT_W-1:0] word,
  output logic [PORT_W-1:0] rd_data
);
  logic [PORT_W-1:0] rd_q, rd_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
      rd_p <= '0;
    end else begin
      if (take) rd_q <= word;
      rd_p <= rd_q;
    end
  end

  assign rd_data = pipe ? rd_p : rd_q;

  // R11: the first read register only changes on an accepted read
  p_rd_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(rd_q));
  // R9: the pipeline register trails the first one by exactly one edge
  p_pipe_lag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (rd_p == $past(rd_q)));
endmodule

// File: rtl/cfgw_fifo.sv
`timescale 1ns/1ps
module cfgw_fifo
  import cfgw_fifo_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2:0]         wr_width,
  input  logic [2:0]         rd_width,
  input  logic [PORT_W-1:0]  wr_data,
  input  logic               wr_en_n,
  input  logic               wr_hold,
  input  logic               rd_en,
  input  logic               rd_hold,
  input  logic [SPACE_W-1:0] af_lvl,
  input  logic [SPACE_W-1:0] ae_lvl,
  input  logic               stop_full,
  input  logic               stop_empty,
  input  logic               rd_pipe,
  output logic [PORT_W-1:0]  rd_data,
  output logic               full,
  output logic               empty,
  output logic               afull,
  output logic               aempty
);
  logic [PTR_W-1:0]  wptr, rptr, wptr_nxt, rptr_nxt, wstep, rstep, diff, room;
  logic              wr_req, rd_req, wr_go, rd_go, wr_blocked, rd_blocked;
  logic [PORT_W-1:0] rword;

  assign wstep = step_of(wr_width);
  assign rstep = step_of(rd_width);
  assign diff  = wptr - rptr;
  assign room  = CAP - diff;

  assign wr_req     = !wr_en_n && !wr_hold && code_ok(wr_width);
  assign rd_req     = rd_en && !rd_hold && code_ok(rd_width);
  assign wr_blocked = stop_full && (room < wstep);
  assign rd_blocked = stop_empty && (diff < rstep);
  assign wr_go      = wr_req && !wr_blocked;
  assign rd_go      = rd_req && !rd_blocked;

  cfgw_ptr u_wptr (.clk(clk), .rst_n(rst_n), .go(wr_go), .step(wstep),
                   .ptr(wptr), .ptr_nxt(wptr_nxt));
  cfgw_ptr u_rptr (.clk(clk), .rst_n(rst_n), .go(rd_go), .step(rstep),
                   .ptr(rptr), .ptr_nxt(rptr_nxt));

  cfgw_store u_store (.clk(clk), .we(wr_go), .wcode(wr_width), .waddr(wptr[SPACE_W-1:0]),
                      .wdata(wr_data), .rcode(rd_width), .raddr(rptr[SPACE_W-1:0]),
                      .rword(rword));

  cfgw_flags u_flags (.clk(clk), .rst_n(rst_n), .wptr_nxt(wptr_nxt), .rptr_nxt(rptr_nxt),
                      .af_lvl(af_lvl), .ae_lvl(ae_lvl), .wcode(wr_width), .rcode(rd_width),
                      .full(full), .empty(empty), .afull(afull), .aempty(aempty));

  cfgw_rdport u_rd (.clk(clk), .rst_n(rst_n), .take(rd_go), .pipe(rd_pipe),
                    .word(rword), .rd_data(rd_data));

  // R6: with the guard on, a write request while full does not move the write side
  p_stop_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_full && full && wr_req) |=> $stable(wptr));
  // R7: with the guard on, a read request while empty does not move the read side
  p_stop_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_empty && empty && rd_req) |=> $stable(rptr));
  // R1: an illegal code never yields an accepted operation
  p_bad_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!code_ok(wr_width) |-> !wr_go) and (!code_ok(rd_width) |-> !rd_go));
  // R10: reset state seen at the ports
  p_reset_state_r10: assert property (@(posedge clk)
    !rst_n |-> (empty && aempty && !full && !afull && rd_data == '0));
endmodule

// File: tb/cfgw_fifo_bench.sv
`timescale 1ns/1ps
module cfgw_fifo_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic [2:0]  wr_width = 3'd3, rd_width = 3'd3;
  logic [17:0] wr_data = '0;
  logic        wr_en_n = 1'b1, wr_hold = 1'b0, rd_en = 1'b0, rd_hold = 1'b0;
  logic [11:0] af_lvl = 12'hFFF, ae_lvl = 12'h000;
  logic        stop_full = 1'b1, stop_empty = 1'b1, rd_pipe = 1'b0;
  logic [17:0] rd_data;
  logic        full, empty, afull, aempty;
  int          total = 0, bad = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  cfgw_fifo u_cfgw_fifo (.clk(clk), .rst_n(rst_n), .wr_width(wr_width), .rd_width(rd_width),
    .wr_data(wr_data), .wr_en_n(wr_en_n), .wr_hold(wr_hold), .rd_en(rd_en), .rd_hold(rd_hold),
    .af_lvl(af_lvl), .ae_lvl(ae_lvl), .stop_full(stop_full), .stop_empty(stop_empty),
    .rd_pipe(rd_pipe), .rd_data(rd_data), .full(full), .empty(empty), .afull(afull),
    .aempty(aempty));

  task automatic chk(string req, logic [17:0] act, logic [17:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // all drivers change at the falling edge; samples are taken there too
  task automatic reset_all(logic [2:0] ww, logic [2:0] rw);
    rst_n = 1'b0;
    wr_width = ww; rd_width = rw;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr1(logic [17:0] d);
    wr_data = d; wr_en_n = 1'b0;
    @(negedge clk);
    wr_en_n = 1'b1;
  endtask

  task automatic rd1();
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic t_reset_retain();
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
    wr_width = 3'd3; rd_width = 3'd3;
    wr1(18'h155);
    rd1();
    chk("R9 plain read", rd_data, 18'h155);
    wr1(18'h0AA);
    rst_n = 1'b0;
    wr_en_n = 1'b0; wr_hold = 1'b0;
    @(negedge clk);
    chk("R10 empty in reset", {17'b0, empty}, 18'd1);
    chk("R10 aempty in reset", {17'b0, aempty}, 18'd1);
    chk("R10 full in reset", {17'b0, full}, 18'd0);
    chk("R10 afull in reset", {17'b0, afull}, 18'd0);
    chk("R10 rd_data in reset", rd_data, 18'd0);
    wr_en_n = 1'b1;
    rst_n = 1'b1;
    wr1(18'h033);
    rd1();
    chk("R10 memory kept", rd_data, 18'h033);
  endtask

  task automatic t_retain_slot();
    reset_all(3'd3, 3'd3);
    wr1(18'h1F1);
    reset_all(3'd3, 3'd3);
    stop_empty = 1'b0;
    rd1();
    chk("R10 slot 0 survives reset", rd_data, 18'h1F1);
    stop_empty = 1'b1;
  endtask

  task automatic t_holds();
    reset_all(3'd3, 3'd3);
    wr_hold = 1'b1;
    wr1(18'h0CC);
    wr_hold = 1'b0;
    chk("R2 write hold keeps empty", {17'b0, empty}, 18'd1);
    wr1(18'h0CC);
    chk("R2 write accepted", {17'b0, empty}, 18'd0);
    rd_hold = 1'b1;
    rd1();
    rd_hold = 1'b0;
    chk("R2 read hold keeps data", rd_data, 18'd0);
    chk("R11 no read keeps rd_data", rd_data, 18'd0);
    chk("R2 read hold keeps level", {17'b0, empty}, 18'd0);
    rd1();
    chk("R2 read accepted", rd_data, 18'h0CC);
    chk("R4 empty after drain", {17'b0, empty}, 18'd1);
  endtask

  task automatic t_mixed_9_1();
    logic [8:0] v;
    v = 9'h1A5;
    reset_all(3'd3, 3'd0);
    wr1({9'b0, v});
    for (int i = 0; i < 8; i++) begin
      rd1();
      chk("R3 width 1 from width 9", rd_data, {17'b0, v[i]});
    end
    chk("R1 eight 1-bit reads drain one 9-bit word", {17'b0, empty}, 18'd1);
  endtask

  task automatic t_wide_18_9();
    reset_all(3'd4, 3'd3);
    wr1(18'h2A5C3);
    rd1();
    chk("R3 low slot of 18", rd_data, 18'h1C3);
    chk("R4 half drained", {17'b0, empty}, 18'd0);
    rd1();
    chk("R3 high slot of 18", rd_data, 18'h152);
    chk("R1 two 9 reads drain one 18", {17'b0, empty}, 18'd1);
  endtask

  task automatic t_nibble_pair();
    logic [1:0] exp_p [4];
    exp_p[0] = 2'b01; exp_p[1] = 2'b10; exp_p[2] = 2'b10; exp_p[3] = 2'b01;
    reset_all(3'd2, 3'd1);
    wr1(18'h9);
    wr1(18'h6);
    for (int i = 0; i < 4; i++) begin
      rd1();
      chk("R3 width 2 from width 4", rd_data, {16'b0, exp_p[i]});
    end
    chk("R1 steps 4 and 2 balance", {17'b0, empty}, 18'd1);
  endtask

  task automatic t_thresholds();
    af_lvl = 12'd25; ae_lvl = 12'd15;
    reset_all(3'd3, 3'd3);
    wr1(18'h1);
    chk("R5 aempty at diff 8 (15 masked to 8)", {17'b0, aempty}, 18'd1);
    chk("R5 afull low at diff 8", {17'b0, afull}, 18'd0);
    wr1(18'h2);
    chk("R5 aempty low at diff 16", {17'b0, aempty}, 18'd0);
    chk("R5 afull low at diff 16", {17'b0, afull}, 18'd0);
    wr1(18'h3);
    chk("R5 afull at diff 24 (25 masked to 24)", {17'b0, afull}, 18'd1);
    af_lvl = 12'hFFF; ae_lvl = 12'h000;
  endtask

  task automatic t_fill_stop();
    stop_full = 1'b1;
    reset_all(3'd4, 3'd4);
    wr_en_n = 1'b0;
    for (int i = 0; i < 256; i++) begin
      wr_data = 18'(i * 3 + 1);
      @(negedge clk);
      if (i == 253) chk("R5 afull low at 254 words", {17'b0, afull}, 18'd0);
      if (i == 254) begin
        chk("R5 afull at 255 words", {17'b0, afull}, 18'd1);
        chk("R4 not full at 255 words", {17'b0, full}, 18'd0);
      end
    end
    wr_en_n = 1'b1;
    chk("R4 full at 256 words", {17'b0, full}, 18'd1);
    wr1(18'h3FFFF);
    chk("R6 full holds after refused write", {17'b0, full}, 18'd1);
    for (int i = 0; i < 256; i++) begin
      rd1();
      chk("R6 stored data intact", rd_data, 18'(i * 3 + 1));
    end
    chk("R4 empty after draining 256", {17'b0, empty}, 18'd1);
  endtask

  task automatic t_stop_empty();
    reset_all(3'd3, 3'd3);
    stop_empty = 1'b1;
    rd1();
    chk("R7 read while empty keeps rd_data", rd_data, 18'd0);
    chk("R7 read while empty keeps empty", {17'b0, empty}, 18'd1);
    wr1(18'h0AB);
    rd1();
    chk("R7 read side did not move", rd_data, 18'h0AB);
  endtask

  task automatic t_wrap_empty();
    reset_all(3'd3, 3'd3);
    stop_empty = 1'b0;
    rd1();
    chk("R8 read past empty clears empty", {17'b0, empty}, 18'd0);
    chk("R8 wrapped diff is not full", {17'b0, full}, 18'd0);
    wr1(18'h011);
    chk("R8 write brings diff back to 0", {17'b0, empty}, 18'd1);
    stop_empty = 1'b1;
  endtask

  task automatic t_pipe();
    reset_all(3'd3, 3'd3);
    rd_pipe = 1'b1;
    wr1(18'h111);
    wr1(18'h022);
    rd1();
    chk("R9 pipe lags one edge", rd_data, 18'd0);
    @(negedge clk);
    chk("R9 pipe shows first word", rd_data, 18'h111);
    rd1();
    chk("R9 pipe still old word", rd_data, 18'h111);
    @(negedge clk);
    chk("R9 pipe shows second word", rd_data, 18'h022);
    rd_pipe = 1'b0;
  endtask

  task automatic t_illegal();
    reset_all(3'd5, 3'd3);
    wr1(18'h0EE);
    chk("R1 illegal write code ignored", {17'b0, empty}, 18'd1);
    wr_width = 3'd3;
    wr1(18'h0EE);
    rd_width = 3'd7;
    rd1();
    chk("R1 illegal read code ignored", rd_data, 18'd0);
    chk("R1 illegal read keeps level", {17'b0, empty}, 18'd0);
  endtask

  initial begin
    #1 rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    t_reset_retain();
    t_retain_slot();
    t_holds();
    t_mixed_9_1();
    t_wide_18_9();
    t_nibble_pair();
    t_thresholds();
    t_fill_stop();
    t_stop_empty();
    t_wrap_empty();
    t_pipe();
    t_illegal();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule